// File: doc/BRIEF.md
# Thermal Alarm and Shutdown Comparator

This block watches the most recent 12-bit conversion code from each of up to three temperature sensor channels. The code falls as the die gets hotter, so "hotter than a limit" means a code numerically below the limit code. Each channel has two limits that software can program. The first is an alarm level with a separate release (hysteresis) level. The second is an independent shutdown level.

A comparison runs only when a channel presents a new sample on its valid strobe. When an alarm starts or a shutdown condition is seen, the block sets a sticky status bit. Software clears a status bit by writing a 1 to it. The status bits, masked by per-bit enables, are combined into a single registered interrupt line.

Software reaches the thresholds, the enables and the status through a simple single-cycle register port: a write strobe, an address and write data, with combinational read data.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, all status bits, enables and thresholds read as zero and `irq` is low.
- R2: The alarm register of channel c is at byte address 0x50+4c. Its hot level is bits 27:16 and its release level is bits 11:0. All other bits read as zero.
- R3: The shutdown register of channel c is at byte address 0x60+4c, with its level in bits 27:16. All other bits read as zero.
- R4: When a sample with a code strictly below the hot level arrives on a channel whose alarm is inactive, the alarm becomes active and status bit c (of the status register at 0x48) is set. A code equal to the hot level does not trigger the alarm.
- R5: An active alarm sets no further status. It stays active until a sample with a code strictly above the release level arrives. A code equal to the release level keeps it active.
- R6: Status bit 4+c is set on every sample whose code is strictly below the shutdown level of channel c, but only while enable bit 4+c is set.
- R7: Without a valid strobe, a channel changes neither its alarm state nor any status bit.
- R8: Writing 0x48 clears each status bit written as 1 and leaves the bits written as 0 unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: The enable register at 0x44 uses the status bit positions. `irq` is high one cycle after any status bit and its enable are both set.
- R10: Channels are evaluated independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | NCH | Per-channel new-sample strobe |
| samp_code | input | NCH*12 | Per-channel latest code, channel c at bits 12c+11:12c |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: three channels, 8-bit addresses and 32-bit data. With these values the full status layout is reachable, including alarm bits 0 to 2 and shutdown bits 4 to 6, so the bench can show that one channel's events leave the other channels' bits untouched. A vector table steps channel 0 through the alarm hysteresis loop, covering codes equal to the hot level and to the release level. Directed tests then cover shutdown gating, clear-versus-set collisions and the one-cycle interrupt latency.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
    localparam int CODE_W     = 12;
    localparam int STAT_W     = 8;
    localparam int SHUT_OFS   = 4;
    localparam int ADDR_EN    = 'h44;
    localparam int ADDR_STAT  = 'h48;
    localparam int ADDR_ALARM = 'h50;
    localparam int ADDR_SHUT  = 'h60;
    localparam int HOT_LSB    = 16;
    localparam int REL_LSB    = 0;

    typedef struct packed {
        logic [CODE_W-1:0] hot;
        logic [CODE_W-1:0] rel;
    } alarm_cfg_t;

    // Status/enable bits that exist for a given channel count
    function automatic logic [STAT_W-1:0] stat_mask(input int nch);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int c = 0; c < nch; c++) begin
            m[c]            = 1'b1;
            m[SHUT_OFS + c] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/trip_channel.sv
module trip_channel
    import thermal_trip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  alarm_cfg_t        acfg,
    input  logic [CODE_W-1:0] shut_lvl,
    input  logic              shut_en,
    output logic              alarm_evt,
    output logic              shut_evt
);
    logic active_q;

    assign alarm_evt = valid && !active_q && (code < acfg.hot);
    assign shut_evt  = valid && shut_en && (code < shut_lvl);

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= 1'b0;
        else if (valid) begin
            if (!active_q && code < acfg.hot)
                active_q <= 1'b1;
            else if (active_q && code > acfg.rel)
                active_q <= 1'b0;
        end
    end

    p_hold_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(active_q));
    p_enter_alarm_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !active_q && code < acfg.hot) |=> active_q);
    p_release_alarm_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && active_q && code > acfg.rel) |=> !active_q);
    p_stay_alarm_r5: assert property (@(posedge clk) disable iff (rst)
        (active_q && !(valid && code > acfg.rel)) |=> active_q);
endmodule

// File: rtl/trip_status.sv
module trip_status
    import thermal_trip_pkg::*;
#(
    parameter logic [STAT_W-1:0] MASK = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic [STAT_W-1:0] en,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= ((status & ~clr_eff) | set_vec) & MASK;
            irq    <= |(status & en);
        end
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status & $past(set_vec & MASK)) == $past(set_vec & MASK)));
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_we && set_vec == '0) |=> ((status & $past(clr_vec)) == '0));
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ((status & en) == '0) |=> !irq);
    p_irq_fire_r9: assert property (@(posedge clk) disable iff (rst)
        ((status & en) != '0) |=> irq);
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
    import thermal_trip_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH-1:0]        samp_valid,
    input  logic [NCH*CODE_W-1:0] samp_code,
    input  logic                  reg_we,
    input  logic [AW-1:0]         reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic                  irq
);
    localparam logic [STAT_W-1:0] MASK = stat_mask(NCH);

    alarm_cfg_t        acfg_q  [NCH];
    logic [CODE_W-1:0] shut_q  [NCH];
    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] set_vec;
    logic [NCH-1:0]    alarm_evt;
    logic [NCH-1:0]    shut_evt;
    logic              stat_wr;

    initial begin
        if (NCH < 1 || NCH > SHUT_OFS) $error("NCH out of range");
    end

    assign stat_wr = reg_we && (reg_addr == AW'(ADDR_STAT));

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (reg_we && reg_addr == AW'(ADDR_EN))
            en_q <= reg_wdata[STAT_W-1:0] & MASK;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                acfg_q[c] <= '0;
                shut_q[c] <= '0;
            end else if (reg_we) begin
                if (reg_addr == AW'(ADDR_ALARM + 4*c)) begin
                    acfg_q[c].hot <= reg_wdata[HOT_LSB +: CODE_W];
                    acfg_q[c].rel <= reg_wdata[REL_LSB +: CODE_W];
                end
                if (reg_addr == AW'(ADDR_SHUT + 4*c))
                    shut_q[c] <= reg_wdata[HOT_LSB +: CODE_W];
            end
        end

        trip_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .valid     (samp_valid[c]),
            .code      (samp_code[c*CODE_W +: CODE_W]),
            .acfg      (acfg_q[c]),
            .shut_lvl  (shut_q[c]),
            .shut_en   (en_q[SHUT_OFS + c]),
            .alarm_evt (alarm_evt[c]),
            .shut_evt  (shut_evt[c])
        );

        p_alarm_sets_r4: assert property (@(posedge clk) disable iff (rst)
            alarm_evt[c] |=> status[c]);
        p_shut_sets_r6: assert property (@(posedge clk) disable iff (rst)
            shut_evt[c] |=> status[SHUT_OFS + c]);
        p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
            (!samp_valid[c] && !stat_wr) |=>
                (status[c] == $past(status[c]) &&
                 status[SHUT_OFS + c] == $past(status[SHUT_OFS + c])));
    end

    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH; c++) begin
            set_vec[c]            = alarm_evt[c];
            set_vec[SHUT_OFS + c] = shut_evt[c];
        end
    end

    trip_status #(.MASK(MASK)) u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_we  (stat_wr),
        .clr_vec (reg_wdata[STAT_W-1:0]),
        .en      (en_q),
        .status  (status),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_EN))
            reg_rdata[STAT_W-1:0] = en_q;
        if (reg_addr == AW'(ADDR_STAT))
            reg_rdata[STAT_W-1:0] = status;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(ADDR_ALARM + 4*c)) begin
                reg_rdata[HOT_LSB +: CODE_W] = acfg_q[c].hot;
                reg_rdata[REL_LSB +: CODE_W] = acfg_q[c].rel;
            end
            if (reg_addr == AW'(ADDR_SHUT + 4*c))
                reg_rdata[HOT_LSB +: CODE_W] = shut_q[c];
        end
    end

    p_status_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (status & ~MASK) == '0);
endmodule

// File: tb/test_thermal_trip_monitor.sv
module test_thermal_trip_monitor;
    localparam int NCH = 3;
    localparam int CW  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NCH-1:0] samp_valid = '0;
    logic [NCH*CW-1:0] samp_code = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    thermal_trip_monitor i_thermal_trip_monitor (
        .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_code(samp_code),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {expected new alarm status bit, code}: channel 0, hot 0x400, release 0x480
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 12'h500}, {1'b0, 12'h400}, {1'b1, 12'h3FF}, {1'b0, 12'h300},
        {1'b0, 12'h480}, {1'b0, 12'h3F0}, {1'b0, 12'h481}, {1'b1, 12'h3FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic sample(input int ch, input logic [11:0] code);
        samp_valid[ch] = 1'b1; samp_code[ch*CW +: CW] = code;
        @(posedge clk); @(negedge clk);
        samp_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h48, d); chk("R1 status", d, 0);
        rd(8'h44, d); chk("R1 enable", d, 0);
        rd(8'h50, d); chk("R1 alarm0", d, 0);
        rd(8'h68, d); chk("R1 shut2", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 / R3 register layout
        wr(8'h54, 32'hFABC_FDEF);
        rd(8'h54, d); chk("R2 alarm1 fields", d, 32'h0ABC_0DEF);
        wr(8'h64, 32'hFFFF_FFFF);
        rd(8'h64, d); chk("R3 shut1 field", d, 32'h0FFF_0000);
        wr(8'h54, 0); wr(8'h64, 0);

        // R4 / R5 vector walk
        wr(8'h50, 32'h0400_0480);
        foreach (VEC[i]) begin
            sample(0, VEC[i][11:0]);
            rd(8'h48, d);
            chk($sformatf("R4/R5 vec %0d", i), d, {31'b0, VEC[i][12]});
            wr(8'h48, 32'hFF);
        end

        // R7: no valid, no evaluation (code below hot but strobe low)
        sample(0, 12'h600);   // release
        samp_code[0 +: CW] = 12'h100;
        repeat (3) @(negedge clk);
        rd(8'h48, d); chk("R7 no strobe", d, 0);

        // R6 shutdown gating on channel 1
        wr(8'h64, 32'h0200_0000);
        sample(1, 12'h100);
        rd(8'h48, d); chk("R6 disabled", d, 0);
        wr(8'h44, 32'h20);
        sample(1, 12'h200);
        rd(8'h48, d); chk("R6 equal level", d, 0);
        sample(1, 12'h100);
        rd(8'h48, d); chk("R6 set", d, 32'h20);
        wr(8'h48, 32'h20);
        sample(1, 12'h100);
        rd(8'h48, d); chk("R6 set again", d, 32'h20);

        // R10 channel 2 alarm only
        wr(8'h48, 32'hFF);
        wr(8'h58, 32'h0800_0900);
        sample(2, 12'h100);
        rd(8'h48, d); chk("R10 ch2 only", d, 32'h04);

        // R8 partial clear
        sample(1, 12'h100);  // adds bit5
        wr(8'h48, 32'h04);
        rd(8'h48, d); chk("R8 partial w1c", d, 32'h20);
        wr(8'h48, 32'hFF);

        // R8 set beats clear: channel 0 inactive (released above)
        reg_we = 1'b1; reg_addr = 8'h48; reg_wdata = 32'h01;
        samp_valid[0] = 1'b1; samp_code[0 +: CW] = 12'h100;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0; samp_valid = '0;
        rd(8'h48, d); chk("R8 set wins", d, 32'h01);
        wr(8'h48, 32'hFF);

        // R9 irq latency
        sample(0, 12'h700);  // release alarm 0
        wr(8'h44, 32'h01);
        chk("R9 irq idle", {31'b0, irq}, 0);
        samp_valid[0] = 1'b1; samp_code[0 +: CW] = 12'h100;
        @(posedge clk); #1;
        samp_valid = '0;
        chk("R9 irq not yet", {31'b0, irq}, 0);
        @(posedge clk); #1;
        chk("R9 irq high", {31'b0, irq}, 1);
        @(negedge clk);
        wr(8'h44, 32'h00);
        @(negedge clk);
        chk("R9 irq masked", {31'b0, irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule